// File: doc/BRIEF.md
# Register Unlock Sequence Checker

This block guards a peripheral that must stay dormant until software has written a fixed series of key bytes to a fixed series of register offsets. It watches a simple synchronous register-write bus made of an address, a 32-bit write word and a one-cycle write strobe. It steps through the expected writes in order. Once every step has matched, it raises a sticky enable that lets the downstream timekeeping logic run and accept configuration.

A write with the wrong value, or a write to a key offset out of turn, throws the checker back to its first step. Writes to offsets that hold no key leave the progress untouched. A 3-bit progress index is brought out for debug. It shows how many keys have matched so far, and shows 7 once the block is open.

Top module: `unlock_guard`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `unlocked_o` is 0 and `step_o` is 0.
- R2: The keys must arrive in this order (offset : low byte): 0x04 : 0xC6, 0x08 : 0x9A, 0x0C : 0x59, 0x10 : 0xA3, 0x14 : 0x57, 0x18 : 0x67, 0x1C : 0xD2. These seven offsets are the key offsets.
- R3: A strobed write that carries the expected key at the expected offset raises `step_o` by one. The new value shows in the cycle after the strobe edge.
- R4: The clock edge that samples the seventh matching write sets `unlocked_o` to 1 and `step_o` to 7.
- R5: A strobed write to the expected key offset with a wrong low byte returns `step_o` to 0.
- R6: A strobed write to a key offset other than the expected one returns `step_o` to 0. This holds even when the byte is the correct key for that other offset.
- R7: A strobed write to a non-key offset leaves `step_o` unchanged. Examples are 0x00, 0x05, 0x20 and 0x40. Cycles with `we_i` low also leave `step_o` unchanged.
- R8: Only bits 7:0 of `wdata_i` are compared. Bits 31:8 are ignored.
- R9: Once `unlocked_o` is 1, it stays 1 and `step_o` stays 7 until reset, whatever is then written.
- R10: After a restart, the full sequence written again from its first key unlocks the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | ADDR_W (8) | Byte offset of the write |
| wdata_i | input | DATA_W (32) | Write word; the key is in the low byte |
| unlocked_o | output | 1 | High once the full key sequence has matched |
| step_o | output | 3 | Keys matched so far, 0 to 6; 7 when unlocked |

## Verification
The hardest situations to reach are the mid-sequence ones: a write that is correct on its own but arrives out of turn, and stray writes landing between two keys. Only a partly completed sequence exposes either of them. The directed tests first drive a known prefix of correct keys and confirm the index after each one. Only then do they inject the disturbing write. This way the restart-versus-hold decision is observed from a non-zero step, where a faulty design would differ.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int unsigned KEY_COUNT  = 7;
  localparam int unsigned KEY_W      = 8;
  localparam int unsigned STEP_W     = $clog2(KEY_COUNT + 1);
  localparam int unsigned KEY_BASE   = 4;
  localparam int unsigned KEY_STRIDE = 4;

  // key bytes in required order
  function automatic logic [KEY_W-1:0] key_value(int unsigned idx);
    case (idx)
      0:       return 8'hC6;
      1:       return 8'h9A;
      2:       return 8'h59;
      3:       return 8'hA3;
      4:       return 8'h57;
      5:       return 8'h67;
      6:       return 8'hD2;
      default: return '0;
    endcase
  endfunction

  function automatic int unsigned key_offset(int unsigned idx);
    return KEY_BASE + KEY_STRIDE * idx;
  endfunction
endpackage

// File: rtl/unlock_key_table.sv
module unlock_key_table
  import unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] exp_addr_o,
  output logic [KEY_W-1:0]  exp_key_o
);
  always_comb begin
    exp_addr_o = '0;
    exp_key_o  = '0;
    for (int i = 0; i < KEY_COUNT; i++) begin
      if (step_i == STEP_W'(i)) begin
        exp_addr_o = ADDR_W'(key_offset(i));
        exp_key_o  = key_value(i);
      end
    end
  end
endmodule

// File: rtl/unlock_write_decode.sv
module unlock_write_decode
  import unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [ADDR_W-1:0] exp_addr_i,
  input  logic [KEY_W-1:0]  exp_key_i,
  output logic              hit_o,
  output logic              match_o
);
  logic [KEY_COUNT-1:0] hit_vec;

  for (genvar g = 0; g < KEY_COUNT; g++) begin : g_hit
    assign hit_vec[g] = (addr_i == ADDR_W'(key_offset(g)));
  end

  assign hit_o   = we_i & (|hit_vec);
  assign match_o = we_i & (addr_i == exp_addr_i) & (key_i == exp_key_i);
endmodule

// File: rtl/unlock_step_fsm.sv
module unlock_step_fsm
  import unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              match_i,
  output logic [STEP_W-1:0] step_q_o,
  output logic              open_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_COUNT - 1);

  typedef enum logic {ST_SEEK, ST_OPEN} state_e;
  state_e            state_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEEK;
      step_q  <= '0;
    end else if (state_q == ST_SEEK && hit_i) begin
      if (match_i) begin
        if (step_q == LAST_STEP) state_q <= ST_OPEN;
        else                     step_q  <= step_q + 1'b1;
      end else begin
        step_q <= '0;
      end
    end
  end

  assign step_q_o = step_q;
  assign open_o   = (state_q == ST_OPEN);
endmodule

// File: rtl/unlock_guard.sv
module unlock_guard
  import unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] OPEN_CODE = STEP_W'(KEY_COUNT);

  logic [ADDR_W-1:0] exp_addr;
  logic [KEY_W-1:0]  exp_key;
  logic              hit, match, open;
  logic [STEP_W-1:0] step_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:KEY_W];

  unlock_key_table #(.ADDR_W(ADDR_W)) u_table (
    .step_i     (step_q),
    .exp_addr_o (exp_addr),
    .exp_key_o  (exp_key)
  );

  unlock_write_decode #(.ADDR_W(ADDR_W)) u_decode (
    .we_i       (we_i),
    .addr_i     (addr_i),
    .key_i      (wdata_i[KEY_W-1:0]),
    .exp_addr_i (exp_addr),
    .exp_key_i  (exp_key),
    .hit_o      (hit),
    .match_o    (match)
  );

  unlock_step_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .match_i  (match),
    .step_q_o (step_q),
    .open_o   (open)
  );

  assign unlocked_o = open;
  assign step_o     = open ? OPEN_CODE : step_q;
endmodule

// File: rtl/unlock_guard_chk.sv
module unlock_guard_chk
  import unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              unlocked_o,
  input logic [STEP_W-1:0] step_o
);
  logic is_key;
  logic unused_chk;
  assign unused_chk = ^wdata_i;

  always_comb begin
    is_key = 1'b0;
    for (int i = 0; i < KEY_COUNT; i++)
      if (addr_i == ADDR_W'(key_offset(i))) is_key = 1'b1;
  end

  AST_STICKY_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |=> (unlocked_o && step_o == STEP_W'(KEY_COUNT))); // R9

  AST_STEP_MOVES_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(step_o) && !unlocked_o) |-> (step_o == '0 || step_o == $past(step_o) + 1'b1)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!we_i || !is_key) |-> $stable(step_o)); // R7

  AST_OPEN_ON_LAST_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> ($past(step_o) == STEP_W'(KEY_COUNT - 1) && $past(we_i)
      && $past(addr_i) == ADDR_W'(key_offset(KEY_COUNT - 1))
      && $past(wdata_i[KEY_W-1:0]) == key_value(KEY_COUNT - 1))); // R4

  AST_RESET_LOCKED: assert property (@(posedge clk_i)
    !rst_ni |-> (!unlocked_o && step_o == '0)); // R1
endmodule

bind unlock_guard unlock_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/unlock_guard_test.sv
module unlock_guard_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        unlocked;
  logic [2:0]  step;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  unlock_guard uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .unlocked_o(unlocked), .step_o(step)
  );

  function automatic logic [7:0] k_addr(int i);
    return 8'(4 + 4 * i);
  endfunction

  function automatic logic [7:0] k_val(int i);
    case (i)
      0: return 8'hC6; 1: return 8'h9A; 2: return 8'h59; 3: return 8'hA3;
      4: return 8'h57; 5: return 8'h67; default: return 8'hD2;
    endcase
  endfunction

  task automatic check(string req, logic [2:0] exp_step, logic exp_unl);
    total++;
    if (step !== exp_step || unlocked !== exp_unl) begin
      bad++;
      $display("FAIL %s: step=%0d unlocked=%0b expected step=%0d unlocked=%0b",
               req, step, unlocked, exp_step, exp_unl);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", 3'd0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", 3'd0, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 3'd0, 1'b0);
  endtask

  task automatic t_full_unlock();
    for (int i = 0; i < 6; i++) begin
      wr(k_addr(i), {24'h0, k_val(i)});
      check("R2 R3", 3'(i + 1), 1'b0);
    end
    wr(k_addr(6), {24'h0, k_val(6)});
    check("R4", 3'd7, 1'b1);
    do_reset();
  endtask

  task automatic t_bad_value();
    for (int i = 0; i < 3; i++) wr(k_addr(i), {24'h0, k_val(i)});
    check("R3", 3'd3, 1'b0);
    wr(k_addr(3), 32'h0000_00A4);
    check("R5", 3'd0, 1'b0);
    do_reset();
  endtask

  task automatic t_bad_order();
    for (int i = 0; i < 2; i++) wr(k_addr(i), {24'h0, k_val(i)});
    check("R3", 3'd2, 1'b0);
    wr(k_addr(4), {24'h0, k_val(4)});
    check("R6", 3'd0, 1'b0);
    for (int i = 0; i < 3; i++) wr(k_addr(i), {24'h0, k_val(i)});
    wr(k_addr(0), {24'h0, k_val(0)});
    check("R6", 3'd0, 1'b0);
    do_reset();
  endtask

  task automatic t_ignored();
    for (int i = 0; i < 2; i++) wr(k_addr(i), {24'h0, k_val(i)});
    wr(8'h40, 32'h0000_0059);
    wr(8'h05, 32'h0000_0000);
    wr(8'h00, 32'h0000_00C6);
    wr(8'h20, 32'h0000_00FF);
    repeat (5) @(negedge clk);
    check("R7", 3'd2, 1'b0);
    @(negedge clk);
    addr = k_addr(2); wdata = 32'h0000_0000;
    @(negedge clk);
    check("R7", 3'd2, 1'b0);
    for (int i = 2; i < 7; i++) wr(k_addr(i), {24'h0, k_val(i)});
    check("R7", 3'd7, 1'b1);
    do_reset();
  endtask

  task automatic t_upper_bits();
    for (int i = 0; i < 4; i++) wr(k_addr(i), {24'hA5F00D ^ 24'(i), k_val(i)});
    check("R8", 3'd4, 1'b0);
    wr(k_addr(4), {24'h000057, 8'h00});
    check("R8", 3'd0, 1'b0);
    do_reset();
  endtask

  task automatic t_sticky();
    for (int i = 0; i < 7; i++) wr(k_addr(i), {24'h0, k_val(i)});
    check("R4", 3'd7, 1'b1);
    wr(k_addr(0), 32'h0000_0000);
    check("R9", 3'd7, 1'b1);
    wr(k_addr(3), {24'h0, k_val(3)});
    wr(8'h40, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check("R9", 3'd7, 1'b1);
    do_reset();
  endtask

  task automatic t_restart();
    for (int i = 0; i < 5; i++) wr(k_addr(i), {24'h0, k_val(i)});
    wr(k_addr(5), 32'h0000_0000);
    check("R10", 3'd0, 1'b0);
    wr(k_addr(0), {24'h0, k_val(0)});
    check("R10", 3'd1, 1'b0);
    for (int i = 1; i < 7; i++) wr(k_addr(i), {24'h0, k_val(i)});
    check("R10", 3'd7, 1'b1);
    do_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_full_unlock();
    t_bad_value();
    t_bad_order();
    t_ignored();
    t_upper_bits();
    t_sticky();
    t_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule